// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge sits between a bus master and a byte-addressable memory port. It reserves two 32 MB alias windows. Each 32-bit word inside a window stands for a single bit of a 1 MB backing region. Any address outside both windows is forwarded to the memory port untouched.

A read of an alias word fetches the backing byte, halfword or word and returns only the selected bit, as 0 or 1. A write of an alias word runs a read-modify-write on the backing location. Bit 0 of the write data sets or clears the selected bit, and every other bit of that location is written back with its old value.

The master side uses a valid/ready handshake. The master holds its request stable until the bridge raises its ready for one cycle. The memory port uses the same handshake, and read data is valid in the cycle of acceptance. Data on both ports is right-justified: a byte occupies bits 7:0, a halfword bits 15:0, and the byte at the lower address is the less significant one.

Top module: `bb_bridge`

## Requirements
- R1: A request whose address lies outside both alias windows reaches the memory port with the same address, size (0 byte, 1 halfword, 2 word), direction and write data. For a read, the memory read data is returned to the master unchanged.
- R2: Alias window 0 spans 0x22000000–0x23FFFFFF and maps to base 0x20000000. Window 1 spans 0x42000000–0x43FFFFFF and maps to base 0x40000000. The backing address is the base ORed with the low 25 bits of the address shifted right by 5.
- R3: For a halfword alias access the backing address has bit 0 cleared. For a word alias access it has bits 1:0 cleared.
- R4: An alias read performs exactly one memory read of the access size. It returns 1 when the selected bit is set and 0 otherwise, with bits 31:1 of the read data always zero.
- R5: An alias write performs one memory read followed by one memory write to the same address and size. The written value differs from the value read in the selected bit only.
- R6: On an alias write, bit 0 of the write data is the new bit value. Write-data bits 31:1 have no effect.
- R7: The master ready rises only after the final memory handshake of the request has completed. It stays high for exactly one cycle, and the memory request stays stable while the memory port is not ready.
- R8: The bit index is taken from address bits starting at bit 2. It is 3 bits wide for byte accesses, 4 bits for halfword accesses and 5 bits for word accesses.
- R9: While reset is high and in the first cycle after it, neither the master ready nor the memory request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_valid | input | 1 | Master request valid |
| m_write | input | 1 | Master request is a write |
| m_addr | input | 32 | Master byte address |
| m_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| m_wdata | input | 32 | Master write data, right-justified |
| m_ready | output | 1 | One-cycle completion pulse |
| m_rdata | output | 32 | Read data, valid with m_ready |
| s_valid | output | 1 | Memory request valid |
| s_write | output | 1 | Memory request is a write |
| s_addr | output | 32 | Memory byte address |
| s_size | output | 2 | Memory access size |
| s_wdata | output | 32 | Memory write data, right-justified |
| s_ready | input | 1 | Memory accepts the request |
| s_rdata | input | 32 | Memory read data, valid with s_ready |

## Verification
The two functions that can share a cycle are acceptance of the backing read data and launch of the merged write-back. With a zero-wait memory, the read handshake and the decision to write back fall on the same edge, so the merged value is built from data captured in that very cycle. The bench provokes this by varying the memory wait from zero to two cycles across the full bit sweep. It judges each write by the recorded order of memory handshakes, the address and size of each, and the full byte neighbourhood of the backing location afterwards.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int BB_DATA_W = 32;
  localparam int BB_IDX_W  = $clog2(BB_DATA_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_RD,
    ST_WR,
    ST_DONE
  } bb_state_e;

  function automatic logic [BB_DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = BB_DATA_W'(32'h0000_00FF);
      SZ_HALF: size_mask = BB_DATA_W'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
  import bb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_WIN   = 2,
  parameter int SPAN_BITS = 25,
  parameter int IDX_W     = BB_IDX_W,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [ADDR_W-1:0] bk_addr,
  output logic [IDX_W-1:0]  bit_idx
);
  // four alias bytes per backing bit, eight bits per backing byte
  localparam int SHIFT = $clog2(4 * 8);

  logic [NUM_WIN-1:0]             win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_addr;
  logic [ADDR_W-1:0]              raw_addr;
  logic [IDX_W-1:0]               raw_idx;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w]  = (addr[ADDR_W-1:SPAN_BITS] == ALIAS_BASE[w][ADDR_W-1:SPAN_BITS]);
    assign win_addr[w] = TARGET_BASE[w] | ADDR_W'(addr[SPAN_BITS-1:0] >> SHIFT);
  end

  always_comb begin
    hit      = 1'b0;
    raw_addr = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_hit[w]) begin
        hit      = 1'b1;
        raw_addr = win_addr[w];
      end
    end
  end

  assign raw_idx = addr[IDX_W+1:2];

  always_comb begin
    bk_addr = raw_addr;
    bit_idx = raw_idx;
    case (size)
      SZ_BYTE: bit_idx = IDX_W'(raw_idx[2:0]);
      SZ_HALF: begin
        bk_addr[0] = 1'b0;
        bit_idx    = IDX_W'(raw_idx[3:0]);
      end
      default: bk_addr[1:0] = 2'b00;
    endcase
  end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
#(
  parameter int DATA_W = BB_DATA_W,
  parameter int IDX_W  = BB_IDX_W
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              set_val,
  output logic [DATA_W-1:0] merged,
  output logic              bit_out
);
  logic [DATA_W-1:0] sel;

  assign sel     = DATA_W'(1) << bit_idx;
  assign merged  = set_val ? (old_val | sel) : (old_val & ~sel);
  assign bit_out = |(old_val & sel);
endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = BB_DATA_W,
  parameter int NUM_WIN   = 2,
  parameter int SPAN_BITS = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_valid,
  input  logic              m_write,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [1:0]        m_size,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_ready,
  output logic [DATA_W-1:0] m_rdata,
  output logic              s_valid,
  output logic              s_write,
  output logic [ADDR_W-1:0] s_addr,
  output logic [1:0]        s_size,
  output logic [DATA_W-1:0] s_wdata,
  input  logic              s_ready,
  input  logic [DATA_W-1:0] s_rdata
);
  localparam int IDX_W = $clog2(DATA_W);

  bb_state_e         state;
  logic              req_write, req_alias;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr, bk_addr_q;
  logic [DATA_W-1:0] req_wdata, old_q, pass_q;
  logic [IDX_W-1:0]  idx_q;

  logic              map_hit;
  logic [ADDR_W-1:0] map_addr;
  logic [IDX_W-1:0]  map_idx;
  logic [DATA_W-1:0] merged;
  logic              bit_out;

  bb_addr_map #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SPAN_BITS(SPAN_BITS), .IDX_W(IDX_W),
    .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE)
  ) map_i (
    .addr(m_addr), .size(m_size), .hit(map_hit), .bk_addr(map_addr), .bit_idx(map_idx)
  );

  bb_bit_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W)) merge_i (
    .old_val(old_q), .bit_idx(idx_q), .set_val(req_wdata[0]),
    .merged(merged), .bit_out(bit_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_write <= 1'b0;
      req_alias <= 1'b0;
      req_size  <= 2'd0;
      req_addr  <= '0;
      bk_addr_q <= '0;
      req_wdata <= '0;
      old_q     <= '0;
      pass_q    <= '0;
      idx_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (m_valid) begin
          req_write <= m_write;
          req_alias <= map_hit;
          req_size  <= m_size;
          req_addr  <= m_addr;
          bk_addr_q <= map_addr;
          req_wdata <= m_wdata;
          idx_q     <= map_idx;
          pass_q    <= '0;
          state     <= map_hit ? ST_RD : ST_PASS;
        end
        ST_PASS: if (s_ready) begin
          if (!req_write) pass_q <= s_rdata;
          state <= ST_DONE;
        end
        ST_RD: if (s_ready) begin
          old_q <= s_rdata & size_mask(req_size);
          state <= req_write ? ST_WR : ST_DONE;
        end
        ST_WR: if (s_ready) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign s_valid = (state == ST_PASS) || (state == ST_RD) || (state == ST_WR);
  assign s_write = (state == ST_PASS) ? req_write : (state == ST_WR);
  assign s_addr  = req_alias ? bk_addr_q : req_addr;
  assign s_size  = req_size;
  assign s_wdata = (state == ST_PASS) ? req_wdata : merged;
  assign m_ready = (state == ST_DONE);
  assign m_rdata = (req_alias && !req_write) ? DATA_W'(bit_out) : pass_q;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    m_ready |=> !m_ready); // R7
  AST_READY_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
    $rose(m_ready) |-> $past(s_valid && s_ready)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_valid && !s_ready |=> s_valid && $stable(s_addr) && $stable(s_write) && $stable(s_wdata)); // R7
  AST_RMW_ORDER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) && ($past(state) != ST_WR) |-> $past(s_valid && s_ready && !s_write)); // R5
  AST_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR) |-> $countones(s_wdata ^ old_q) <= 1); // R5
  AST_ALIGN: assert property (@(posedge clk) disable iff (rst)
    s_valid && req_alias && (s_size == SZ_WORD) |-> s_addr[1:0] == 2'b00); // R3
  AST_ALIGN_HALF: assert property (@(posedge clk) disable iff (rst)
    s_valid && req_alias && (s_size == SZ_HALF) |-> s_addr[0] == 1'b0); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !m_ready && !s_valid); // R9
endmodule

// File: tb/bb_bridge_tb_top.sv
module bb_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_valid = 1'b0, m_write = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [1:0]  m_size = '0;
  logic        m_ready;
  logic [31:0] m_rdata;
  logic        s_valid, s_write, s_ready;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic [1:0]  s_size;

  int n_chk = 0, n_bad = 0;
  int delay = 0;
  int wait_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic        last_w = 1'b0, prev_w = 1'b0;
  logic [31:0] hs_addr = '0, hs_wdata = '0;
  logic [1:0]  hs_size = '0;
  logic [7:0]  mem [0:255];
  int cyc = 0;

  always #10 clk = ~clk;

  bb_bridge dut_i (
    .clk(clk), .rst(rst), .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata),
    .s_valid(s_valid), .s_write(s_write), .s_addr(s_addr), .s_size(s_size),
    .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata)
  );

  function automatic int midx(input logic [31:0] a);
    return {a[30], a[6:0]};
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mem_get(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int i = 0; i < nbytes(sz); i++) v[i*8 +: 8] = mem[midx(a + 32'(i))];
    return v;
  endfunction

  assign s_ready = s_valid && (wait_cnt >= delay);
  assign s_rdata = mem_get(s_addr, s_size);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst || !s_valid || s_ready) wait_cnt <= 0;
    else wait_cnt <= wait_cnt + 1;
    if (s_valid && s_ready) begin
      hs_addr  <= s_addr;
      hs_size  <= s_size;
      hs_wdata <= s_wdata;
      prev_w   <= last_w;
      last_w   <= s_write;
      if (s_write) begin
        wr_cnt <= wr_cnt + 1;
        for (int i = 0; i < nbytes(s_size); i++) mem[midx(s_addr + 32'(i))] <= s_wdata[i*8 +: 8];
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int guard = 0;
    @(negedge clk);
    m_valid = 1'b1; m_write = wr; m_addr = a; m_size = sz; m_wdata = wd;
    do begin
      @(negedge clk);
      guard++;
    end while (!m_ready && guard < 100);
    check(m_ready, "R7 ready timeout", 32'(guard), 32'd100);
    rd = m_rdata;
    m_valid = 1'b0;
    @(negedge clk);
    check(!m_ready, "R7 single ready pulse", 32'(m_ready), 32'd0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    check(1'b0, "watchdog", 32'(cyc), 32'd150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] abase [2] = '{32'h2200_0000, 32'h4200_0000};
    logic [31:0] tbase [2] = '{32'h2000_0000, 32'h4000_0000};
    logic [31:0] rd, v, exp_v, a, bk;
    logic [7:0]  snap [12];
    int r0, w0, bad;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!m_ready && !s_valid, "R9 in reset", {30'b0, m_ready, s_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!m_ready && !s_valid, "R9 after reset", {30'b0, m_ready, s_valid}, 32'd0);

    // pass-through cases
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 32'h2000_0030, 2'd2, 32'hA5A5_1234, rd);
    check(hs_addr == 32'h2000_0030 && hs_size == 2'd2, "R1 pass addr", hs_addr, 32'h2000_0030);
    check(hs_wdata == 32'hA5A5_1234, "R1 pass wdata", hs_wdata, 32'hA5A5_1234);
    check(wr_cnt - w0 == 1 && rd_cnt == r0, "R1 pass one write", 32'(wr_cnt - w0), 32'd1);
    access(1'b0, 32'h2000_0030, 2'd2, 32'h0, rd);
    check(rd == 32'hA5A5_1234, "R1 pass read", rd, 32'hA5A5_1234);
    access(1'b0, 32'h2000_0032, 2'd1, 32'h0, rd);
    check(rd == 32'h0000_A5A5, "R1 pass half read", rd, 32'h0000_A5A5);
    access(1'b0, 32'h2400_0000, 2'd0, 32'h0, rd);
    check(hs_addr == 32'h2400_0000, "R1 above window", hs_addr, 32'h2400_0000);
    check(rd == {24'b0, mem[0]}, "R1 above window data", rd, {24'b0, mem[0]});
    access(1'b0, 32'h21FF_FFFC, 2'd1, 32'h0, rd);
    check(hs_addr == 32'h21FF_FFFC && hs_size == 2'd1, "R1 below window", hs_addr, 32'h21FF_FFFC);

    // top of window: address and index widths
    mem[midx(32'h200F_FFFF)] = 8'h80;
    access(1'b0, 32'h23FF_FFFC, 2'd0, 32'h0, rd);
    check(hs_addr == 32'h200F_FFFF, "R2 top byte addr", hs_addr, 32'h200F_FFFF);
    check(rd == 32'd1, "R8 byte idx 7", rd, 32'd1);
    access(1'b0, 32'h43FF_FFFC, 2'd1, 32'h0, rd);
    check(hs_addr == 32'h400F_FFFE, "R3 top half addr", hs_addr, 32'h400F_FFFE);
    access(1'b0, 32'h43FF_FFFC, 2'd2, 32'h0, rd);
    check(hs_addr == 32'h400F_FFFC, "R3 top word addr", hs_addr, 32'h400F_FFFC);

    // full sweep
    for (int w = 0; w < 2; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int b = 0; b < (8 << sz); b++)
          for (int k = 0; k < 2; k++) begin
            int off = 8 + 36 * k;
            delay = (b + k) % 3;
            a  = abase[w] + 32'(off * 32) + 32'(b * 4);
            bk = tbase[w] | 32'(off);
            for (int i = 0; i < 12; i++) mem[midx(bk - 4 + 32'(i))] = 8'($urandom);
            v = mem_get(bk, 2'(sz));
            r0 = rd_cnt; w0 = wr_cnt;
            access(1'b0, a, 2'(sz), 32'hFFFF_FFFF, rd);
            check(rd == {31'b0, v[b]}, "R4 alias read", rd, {31'b0, v[b]});
            check(hs_addr == bk && hs_size == 2'(sz), "R2 backing addr", hs_addr, bk);
            check(rd_cnt - r0 == 1 && wr_cnt == w0, "R4 one read", 32'(rd_cnt - r0), 32'd1);
            for (int pass = 0; pass < 2; pass++) begin
              for (int i = 0; i < 12; i++) snap[i] = mem[midx(bk - 4 + 32'(i))];
              exp_v = mem_get(bk, 2'(sz));
              exp_v[b] = (pass == 0);
              for (int i = 0; i < nbytes(2'(sz)); i++) snap[4 + i] = exp_v[i*8 +: 8];
              r0 = rd_cnt; w0 = wr_cnt;
              access(1'b1, a, 2'(sz), {31'($urandom), (pass == 0)}, rd);
              check(rd_cnt - r0 == 1 && wr_cnt - w0 == 1 && last_w && !prev_w,
                    "R5 read then write", 32'(rd_cnt - r0), 32'd1);
              check(hs_addr == bk, "R5 write addr", hs_addr, bk);
              bad = 0;
              for (int i = 0; i < 12; i++) if (mem[midx(bk - 4 + 32'(i))] != snap[i]) bad++;
              check(bad == 0, "R6 only selected bit", mem_get(bk, 2'(sz)), exp_v);
              access(1'b0, a, 2'(sz), 32'h0, rd);
              check(rd == 32'(pass == 0), "R8 read back", rd, 32'(pass == 0));
            end
          end
    delay = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule